// File: doc/BRIEF.md
# H-Bridge Gate Enable Logic with Synchronous Rectification

This block turns the state of a full H-bridge into four gate enables: one high-side (source) and one low-side (sink) switch for each of the two half-bridges, A and B. The current-chopping controller sets a drive/decay state. The block also takes the phase, the decay type, a two-bit rectification mode and four synchronous fault flags. While driving, it turns on the diagonal pair that the phase selects. During decay it chooses which switches carry the recirculating current. It then masks the result against the fault flags, and the four enables leave through one register stage.

Synchronous rectification turns on the switches opposite the driving pair during decay, so the current bypasses the body diodes. In the passive setting those switches open again once the winding current reaches zero. In the active setting they stay on for the whole decay. In slow decay, any enabled rectification setting shorts both low-side switches, which brakes the motor. Faults are masked selectively. Over-temperature, regulator undervoltage and logic-supply undervoltage lockout turn every switch off. Charge-pump undervoltage turns off only the high side.

Top module: `hb_gate_logic`

## Requirements
- R1: While `rst_n` is low, all four gate enables are low.
- R2: When `drive_i`=1, the enables one clock later are `src_a`+`snk_b` for `phase_i`=1, and `src_b`+`snk_a` for `phase_i`=0. The other two are low.
- R3: In fast decay (`drive_i`=0, `slow_i`=0) with `sr_mode_i`=00 (disabled), all four enables are low one clock later.
- R4: In fast decay with `sr_mode_i`=10 or 11 (active), the pair opposite the driving pair is on for every decay cycle: `src_b`+`snk_a` for `phase_i`=1 and `src_a`+`snk_b` for `phase_i`=0. `zero_cur_i` has no effect.
- R5: In fast decay with `sr_mode_i`=01 (passive), the opposite pair is on until `zero_cur_i` has been high for `ZC_FILTER` consecutive decay cycles (default 1). From the clock after that, all enables are low for the rest of the decay, even if `zero_cur_i` falls. A drive cycle re-arms this cutoff.
- R6: In slow decay (`slow_i`=1) with `sr_mode_i` nonzero, both sink enables are high and both source enables are low. Passive and active settings behave the same, and `zero_cur_i` has no effect.
- R7: In slow decay with `sr_mode_i`=00, only the sink of the driving pair is on: `snk_b` for `phase_i`=1 and `snk_a` for `phase_i`=0.
- R8: While `flt_temp_i` or `flt_vreg_i` is high, all four enables are low one clock later. Normal gating resumes one clock after the flag clears.
- R9: While `flt_uvlo_i` is high, all four enables are low one clock later.
- R10: While `flt_cpump_i` is high, both source enables are low and the sink enables follow R2–R7.
- R11: The source and sink enables of the same half-bridge are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_i | input | 1 | 1 = drive phase, 0 = current decay |
| phase_i | input | 1 | Drive direction: 1 = A high / B low |
| slow_i | input | 1 | Decay type: 1 = slow, 0 = fast |
| sr_mode_i | input | 2 | Rectification: 00 off, 01 passive, 10/11 active |
| zero_cur_i | input | 1 | Winding current has reached zero |
| flt_temp_i | input | 1 | Over-temperature fault |
| flt_vreg_i | input | 1 | Regulator undervoltage fault |
| flt_cpump_i | input | 1 | Charge-pump undervoltage fault |
| flt_uvlo_i | input | 1 | Logic-supply undervoltage lockout |
| src_a_o | output | 1 | Half-bridge A high-side enable |
| src_b_o | output | 1 | Half-bridge B high-side enable |
| snk_a_o | output | 1 | Half-bridge A low-side enable |
| snk_b_o | output | 1 | Half-bridge B low-side enable |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across each rising edge. They also assume that a fault flag and the control inputs are sampled on the same edge, so the masking always acts on the enables of the next cycle. The stimulus changes every input only on the falling clock edge. It covers each combination of decay type and rectification mode, with faults raised singly and together. The random phase includes zero-current pulses in the middle of a decay and phase reversals during decay. These exercise the passive cutoff and its re-arming without ever driving an input near the sampling edge.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

   typedef enum logic [1:0] {
      SR_OFF        = 2'b00,
      SR_PASSIVE    = 2'b01,
      SR_ACTIVE     = 2'b10,
      SR_ACTIVE_ALT = 2'b11
   } sr_mode_e;

   typedef struct packed {
      logic src_a;
      logic src_b;
      logic snk_a;
      logic snk_b;
   } gates_t;

   localparam gates_t GATES_OFF = '{src_a: 1'b0, src_b: 1'b0, snk_a: 1'b0, snk_b: 1'b0};

   // diagonal pair conducting for a given direction
   function automatic gates_t diag_pair(input logic a_high);
      gates_t g;
      g.src_a = a_high;
      g.snk_b = a_high;
      g.src_b = ~a_high;
      g.snk_a = ~a_high;
      return g;
   endfunction

endpackage

// File: rtl/hb_zc_track.sv
module hb_zc_track #(
   parameter int ZC_FILTER = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_decay_i,
   input  logic zero_cur_i,
   output logic cutoff_o
);

   logic hit;
   logic done_q;

   generate
      if (ZC_FILTER < 1) begin : g_bad_filter
         $error("hb_zc_track: ZC_FILTER must be at least 1");
      end

      if (ZC_FILTER == 1) begin : g_direct
         assign hit = in_decay_i & zero_cur_i;
      end else begin : g_filtered
         localparam int CNT_W = $clog2(ZC_FILTER);
         localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZC_FILTER - 1);
         logic [CNT_W-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (!in_decay_i || !zero_cur_i) begin
               run_q <= '0;
            end else if (run_q != CNT_TOP) begin
               run_q <= run_q + 1'b1;
            end
         end

         assign hit = in_decay_i & zero_cur_i & (run_q == CNT_TOP);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (!in_decay_i) begin
         done_q <= 1'b0;
      end else if (hit) begin
         done_q <= 1'b1;
      end
   end

   assign cutoff_o = done_q | hit;

endmodule

// File: rtl/hb_pair_select.sv
module hb_pair_select
   import hb_gate_pkg::*;
(
   input  logic       drive_i,
   input  logic       phase_i,
   input  logic       slow_i,
   input  logic [1:0] sr_mode_i,
   input  logic       cutoff_i,
   output gates_t     gates_o
);

   sr_mode_e mode;
   logic     sr_on;
   logic     hold_opp;

   assign mode     = sr_mode_e'(sr_mode_i);
   assign sr_on    = (mode != SR_OFF);
   assign hold_opp = (mode == SR_ACTIVE) || (mode == SR_ACTIVE_ALT) ||
                     ((mode == SR_PASSIVE) && !cutoff_i);

   always_comb begin
      gates_o = GATES_OFF;
      if (drive_i) begin
         gates_o = diag_pair(phase_i);
      end else if (slow_i) begin
         if (sr_on) begin
            gates_o.snk_a = 1'b1;
            gates_o.snk_b = 1'b1;
         end else begin
            gates_o.snk_b = phase_i;
            gates_o.snk_a = ~phase_i;
         end
      end else if (hold_opp) begin
         gates_o = diag_pair(~phase_i);
      end
   end

endmodule

// File: rtl/hb_fault_mask.sv
module hb_fault_mask
   import hb_gate_pkg::*;
(
   input  gates_t raw_i,
   input  logic   flt_temp_i,
   input  logic   flt_vreg_i,
   input  logic   flt_cpump_i,
   input  logic   flt_uvlo_i,
   output gates_t gates_o
);

   logic kill_all;

   assign kill_all = flt_temp_i | flt_vreg_i | flt_uvlo_i;

   always_comb begin
      gates_o = raw_i;
      if (kill_all) begin
         gates_o = GATES_OFF;
      end else if (flt_cpump_i) begin
         gates_o.src_a = 1'b0;
         gates_o.src_b = 1'b0;
      end
   end

endmodule

// File: rtl/hb_gate_logic.sv
module hb_gate_logic
   import hb_gate_pkg::*;
#(
   parameter int ZC_FILTER = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       drive_i,
   input  logic       phase_i,
   input  logic       slow_i,
   input  logic [1:0] sr_mode_i,
   input  logic       zero_cur_i,
   input  logic       flt_temp_i,
   input  logic       flt_vreg_i,
   input  logic       flt_cpump_i,
   input  logic       flt_uvlo_i,
   output logic       src_a_o,
   output logic       src_b_o,
   output logic       snk_a_o,
   output logic       snk_b_o
);

   logic   cutoff;
   gates_t raw;
   gates_t masked;
   gates_t out_q;

   hb_zc_track #(.ZC_FILTER(ZC_FILTER)) u_zc (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_decay_i (~drive_i),
      .zero_cur_i (zero_cur_i),
      .cutoff_o   (cutoff)
   );

   hb_pair_select u_sel (
      .drive_i   (drive_i),
      .phase_i   (phase_i),
      .slow_i    (slow_i),
      .sr_mode_i (sr_mode_i),
      .cutoff_i  (cutoff),
      .gates_o   (raw)
   );

   hb_fault_mask u_mask (
      .raw_i       (raw),
      .flt_temp_i  (flt_temp_i),
      .flt_vreg_i  (flt_vreg_i),
      .flt_cpump_i (flt_cpump_i),
      .flt_uvlo_i  (flt_uvlo_i),
      .gates_o     (masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= GATES_OFF;
      end else begin
         out_q <= masked;
      end
   end

   assign src_a_o = out_q.src_a;
   assign src_b_o = out_q.src_b;
   assign snk_a_o = out_q.snk_a;
   assign snk_b_o = out_q.snk_b;

   AST_NO_SHOOT_A: assert property (@(posedge clk) disable iff (!rst_n) !(src_a_o && snk_a_o)); // R11
   AST_NO_SHOOT_B: assert property (@(posedge clk) disable iff (!rst_n) !(src_b_o && snk_b_o)); // R11
   AST_HARD_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(flt_temp_i || flt_vreg_i) |-> !(src_a_o || src_b_o || snk_a_o || snk_b_o)); // R8
   AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(flt_uvlo_i) |-> !(src_a_o || src_b_o || snk_a_o || snk_b_o)); // R9
   AST_CPUMP_SRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(flt_cpump_i) |-> !(src_a_o || src_b_o)); // R10
   AST_SLOW_BRAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !drive_i && slow_i && (sr_mode_i != 2'b00) &&
            !flt_temp_i && !flt_vreg_i && !flt_cpump_i && !flt_uvlo_i)
      |-> (snk_a_o && snk_b_o && !src_a_o && !src_b_o)); // R6
   AST_DRIVE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && drive_i && !flt_temp_i && !flt_vreg_i && !flt_cpump_i && !flt_uvlo_i)
      |-> (src_a_o == $past(phase_i)) && (snk_b_o == $past(phase_i)) &&
          (src_b_o != $past(phase_i)) && (snk_a_o != $past(phase_i))); // R2

endmodule

// File: tb/test_hb_gate_logic.sv
module test_hb_gate_logic;

   localparam int CLK_PERIOD = 10;
   localparam int ZCF        = 1;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       drive = 1'b0, phase = 1'b0, slow = 1'b0, zc = 1'b0;
   logic [1:0] sr = 2'b00;
   logic       f_temp = 1'b0, f_vreg = 1'b0, f_cp = 1'b0, f_uvlo = 1'b0;
   logic       src_a, src_b, snk_a, snk_b;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hb_gate_logic #(.ZC_FILTER(ZCF)) i_hb_gate_logic (
      .clk(clk), .rst_n(rst_n), .drive_i(drive), .phase_i(phase), .slow_i(slow),
      .sr_mode_i(sr), .zero_cur_i(zc), .flt_temp_i(f_temp), .flt_vreg_i(f_vreg),
      .flt_cpump_i(f_cp), .flt_uvlo_i(f_uvlo),
      .src_a_o(src_a), .src_b_o(src_b), .snk_a_o(snk_a), .snk_b_o(snk_b)
   );

   // behavioural reference: expected enables as {src_a, src_b, snk_a, snk_b}
   logic [3:0] exp_g = 4'b0000;
   string      exp_tag = "R1";
   int         zc_run = 0;
   bit         cut_seen = 0;

   always @(posedge clk) begin
      logic [3:0] g;
      string      t;
      bit         hit;
      if (!rst_n) begin
         exp_g    <= 4'b0000;
         exp_tag  <= "R1";
         zc_run    = 0;
         cut_seen  = 0;
      end else begin
         hit = !drive && zc && (zc_run + 1 >= ZCF);
         if (drive) begin
            g = phase ? 4'b1001 : 4'b0110;  t = "R2";
         end else if (slow) begin
            if (sr != 2'b00) begin g = 4'b0011; t = "R6"; end
            else begin g = phase ? 4'b0001 : 4'b0010; t = "R7"; end
         end else if (sr == 2'b00) begin
            g = 4'b0000; t = "R3";
         end else if (sr == 2'b01) begin
            g = (cut_seen || hit) ? 4'b0000 : (phase ? 4'b0110 : 4'b1001); t = "R5";
         end else begin
            g = phase ? 4'b0110 : 4'b1001; t = "R4";
         end
         if (f_temp || f_vreg) begin g = 4'b0000; t = "R8"; end
         else if (f_uvlo) begin g = 4'b0000; t = "R9"; end
         else if (f_cp) begin g[3:2] = 2'b00; t = {t, "/R10"}; end
         exp_g   <= g;
         exp_tag <= t;
         if (drive) begin
            zc_run = 0; cut_seen = 0;
         end else begin
            zc_run = zc ? zc_run + 1 : 0;
            if (hit) cut_seen = 1;
         end
      end
   end

   // comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if ({src_a, src_b, snk_a, snk_b} !== exp_g) begin
            fails++;
            $display("FAIL %s cycle %0d: got %b expected %b", exp_tag, cyc,
                     {src_a, src_b, snk_a, snk_b}, exp_g);
         end
         checks++;
         if ((src_a && snk_a) || (src_b && snk_b)) begin
            fails++;
            $display("FAIL R11 cycle %0d: got %b expected no half-bridge overlap", cyc,
                     {src_a, src_b, snk_a, snk_b});
         end
         cyc++;
         if (cyc > WATCHDOG) begin
            fails++;
            done = 1;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   task automatic ctl(input logic d, input logic p, input logic s, input logic [1:0] m,
                      input logic z, input int n);
      drive = d; phase = p; slow = s; sr = m; zc = z;
      repeat (n) @(negedge clk);
   endtask

   task automatic flt(input logic t, input logic v, input logic c, input logic u);
      f_temp = t; f_vreg = v; f_cp = c; f_uvlo = u;
   endtask

   initial begin
      // R1: reset holds all enables low
      rst_n = 1'b0;
      ctl(1, 1, 0, 2'b10, 0, 4);
      @(negedge clk) rst_n = 1'b1;

      // R2: both drive directions
      ctl(1, 1, 0, 2'b00, 0, 3);
      ctl(1, 0, 0, 2'b00, 0, 3);
      // R3: fast decay, rectification off
      ctl(0, 1, 0, 2'b00, 0, 3);
      // R4: active holds through zero current, both codes
      ctl(1, 1, 0, 2'b10, 0, 2);
      ctl(0, 1, 0, 2'b10, 1, 3);
      ctl(1, 0, 0, 2'b11, 0, 2);
      ctl(0, 0, 0, 2'b11, 1, 3);
      // R5: passive cutoff sticks after zero_cur drops, re-arms on drive
      ctl(1, 1, 0, 2'b01, 0, 2);
      ctl(0, 1, 0, 2'b01, 0, 3);
      ctl(0, 1, 0, 2'b01, 1, 1);
      ctl(0, 1, 0, 2'b01, 0, 3);
      ctl(1, 0, 0, 2'b01, 0, 1);
      ctl(0, 0, 0, 2'b01, 0, 3);
      // R6: slow decay brake, passive and active, zero_cur ignored
      ctl(0, 1, 1, 2'b01, 1, 3);
      ctl(0, 0, 1, 2'b10, 0, 3);
      // R7: slow decay without rectification
      ctl(0, 1, 1, 2'b00, 0, 2);
      ctl(0, 0, 1, 2'b00, 0, 2);
      // R8 / R9: all-off faults, then release
      ctl(1, 1, 0, 2'b10, 0, 0);
      flt(1, 0, 0, 0); repeat (3) @(negedge clk);
      flt(0, 1, 0, 0); repeat (3) @(negedge clk);
      flt(0, 0, 0, 1); repeat (3) @(negedge clk);
      flt(0, 0, 0, 0); repeat (2) @(negedge clk);
      // R10: charge-pump loss kills only high side
      flt(0, 0, 1, 0);
      ctl(1, 1, 0, 2'b10, 0, 2);
      ctl(0, 1, 0, 2'b10, 0, 2);
      ctl(0, 0, 1, 2'b00, 0, 2);
      flt(0, 0, 0, 0);
      // R1 again: mid-run reset
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // random mix, faults rare
      for (int i = 0; i < 3000; i++) begin
         drive  = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 7) == 0) phase = ~phase;
         if ($urandom_range(0, 15) == 0) slow = ~slow;
         if ($urandom_range(0, 31) == 0) sr = 2'($urandom_range(0, 3));
         zc     = ($urandom_range(0, 4) == 0);
         f_temp = ($urandom_range(0, 40) == 0);
         f_vreg = ($urandom_range(0, 40) == 0);
         f_cp   = ($urandom_range(0, 20) == 0);
         f_uvlo = ($urandom_range(0, 40) == 0);
         @(negedge clk);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule